// File: doc/BRIEF.md
# Bit-Time Frame Timestamp Counter

This block keeps a free-running count of bus bit times and uses it to stamp frames. An external bit-time tick makes the count advance by one. Frame acknowledge pulses from the transmit path and the receive path each copy the current count into a stamp register for that direction. The count is held at zero whenever the timer is not effectively enabled. A software enable turns the timer on, and the controller's initialization mode overrides that enable and turns it off.

Stamps leave the block as a registered value with a one-cycle valid strobe. The stamp interface has no ready input and takes no back-pressure. The consumer must accept a stamp in the single cycle its valid is high. Until the next capture, the stamp register keeps its value and can still be read. The enable, init and tick pins are plain level or pulse controls. All logic runs on one clock.

Top module: `tstamp_timer`

## Requirements
- R1: After reset, `count`, both stamps and both valid strobes are zero.
- R2: When the timer is effectively enabled (`timer_en`=1 and `init_mode`=0) and `bit_tick` is high at a clock edge, `count` increases by one at that edge.
- R3: When the timer is effectively enabled and `bit_tick` is low, `count` keeps its value.
- R4: When `timer_en` is 0, `count` becomes zero at the next edge and stays zero, whatever `bit_tick` does.
- R5: When `init_mode` is 1, `count` is forced to zero in the same way, even if `timer_en` is 1.
- R6: The count wraps from 0xFFFF to 0x0000 on a tick and raises no flag.
- R7: A `tx_ack` pulse sampled while the timer is effectively enabled loads `tx_stamp` with the `count` value present at that edge, which is the value before any increment at that edge. `tx_stamp_valid` is high for exactly the following cycle.
- R8: `rx_ack` behaves the same way on `rx_stamp` and `rx_stamp_valid`, and is independent of the transmit side.
- R9: An acknowledge pulse seen while the timer is not effectively enabled raises no valid strobe and leaves that direction's stamp unchanged.
- R10: Acknowledge pulses on both directions at the same edge both capture the same count value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bus bit time |
| timer_en | input | 1 | Software timer enable |
| init_mode | input | 1 | Controller is in initialization mode; disables the timer |
| tx_ack | input | 1 | Transmitted frame acknowledged |
| rx_ack | input | 1 | Received frame acknowledged |
| count | output | 16 | Live timer value |
| tx_stamp | output | 16 | Last transmit timestamp |
| tx_stamp_valid | output | 1 | One-cycle strobe when tx_stamp is loaded |
| rx_stamp | output | 16 | Last receive timestamp |
| rx_stamp_valid | output | 1 | One-cycle strobe when rx_stamp is loaded |

## Verification
A capture and a count increment can happen at the same edge, and so can a capture and the forced clear or the wrap. The bench sweeps all 32 combinations of tick, enable, init and the two acknowledges, starting from a count near zero and again from a count just below 0xFFFF. Each result is compared with an arithmetic model. The model requires the stamp to hold the count before the edge, while `count` already shows the incremented, wrapped or cleared value.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  typedef enum logic [0:0] {DIR_TX = 1'b0, DIR_RX = 1'b1} stamp_dir_e;
  localparam int unsigned NUM_DIR = 2;
endpackage

// File: rtl/tstamp_gate.sv
module tstamp_gate (
  input  logic timer_en,
  input  logic init_mode,
  output logic en_eff
);
  // initialization mode overrides the software enable
  always_comb en_eff = timer_en & ~init_mode;
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_eff,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n || !en_eff) cnt <= '0;
    else if (tick)         cnt <= cnt + ONE; // natural wrap
  end
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_eff,
  input  logic             ack,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] stamp,
  output logic             stamp_valid
);
  logic take;
  always_comb take = ack & en_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp       <= '0;
      stamp_valid <= 1'b0;
    end else begin
      stamp_valid <= take;
      if (take) stamp <= cnt;
    end
  end
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             timer_en,
  input  logic             init_mode,
  input  logic             tx_ack,
  input  logic             rx_ack,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] tx_stamp,
  output logic             tx_stamp_valid,
  output logic [CNT_W-1:0] rx_stamp,
  output logic             rx_stamp_valid
);
  import tstamp_pkg::*;

  logic                en_eff;
  logic [NUM_DIR-1:0]  ack_vec;
  logic [NUM_DIR-1:0]  vld_vec;
  logic [CNT_W-1:0]    stamp_arr [NUM_DIR];

  always_comb begin
    ack_vec[DIR_TX] = tx_ack;
    ack_vec[DIR_RX] = rx_ack;
  end

  tstamp_gate u_gate (
    .timer_en  (timer_en),
    .init_mode (init_mode),
    .en_eff    (en_eff)
  );

  tstamp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_eff (en_eff),
    .tick   (bit_tick),
    .cnt    (count)
  );

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    tstamp_capture #(.CNT_W(CNT_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_eff      (en_eff),
      .ack         (ack_vec[d]),
      .cnt         (count),
      .stamp       (stamp_arr[d]),
      .stamp_valid (vld_vec[d])
    );
  end

  always_comb begin
    tx_stamp       = stamp_arr[DIR_TX];
    tx_stamp_valid = vld_vec[DIR_TX];
    rx_stamp       = stamp_arr[DIR_RX];
    rx_stamp_valid = vld_vec[DIR_RX];
  end
endmodule

// File: rtl/tstamp_checker.sv
module tstamp_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             timer_en,
  input logic             init_mode,
  input logic             tx_ack,
  input logic             rx_ack,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] tx_stamp,
  input logic             tx_stamp_valid,
  input logic [CNT_W-1:0] rx_stamp,
  input logic             rx_stamp_valid
);
  logic on;
  always_comb on = timer_en && !init_mode;

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    on && bit_tick |=> count == CNT_W'($past(count) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    on && !bit_tick |=> $stable(count));
  assert_off_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_en |=> count == '0);
  assert_init_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |=> count == '0);
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    on && bit_tick && (&count) |=> count == '0);
  assert_tx_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    on && tx_ack |=> tx_stamp_valid && tx_stamp == $past(count));
  assert_rx_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    on && rx_ack |=> rx_stamp_valid && rx_stamp == $past(count));
  assert_tx_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(on && tx_ack) |=> !tx_stamp_valid && $stable(tx_stamp));
  assert_rx_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(on && rx_ack) |=> !rx_stamp_valid && $stable(rx_stamp));
  assert_same_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stamp_valid && rx_stamp_valid |-> tx_stamp == rx_stamp);
endmodule

bind tstamp_timer tstamp_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/test_tstamp_timer.sv
module test_tstamp_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, timer_en = 1'b0, init_mode = 1'b0, tx_ack = 1'b0, rx_ack = 1'b0;
  logic [W-1:0] count, tx_stamp, rx_stamp;
  logic tx_stamp_valid, rx_stamp_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] m_cnt = '0, m_tx = '0, m_rx = '0;
  logic m_txv = 1'b0, m_rxv = 1'b0;

  always #5 clk = ~clk;

  tstamp_timer #(.CNT_W(W)) i_tstamp_timer (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive on negedge, clock, sample on next negedge
  task automatic step(input logic tk, input logic en, input logic in, input logic ta, input logic ra);
    logic on;
    logic [W-1:0] prev;
    bit_tick = tk; timer_en = en; init_mode = in; tx_ack = ta; rx_ack = ra;
    @(posedge clk);
    on   = en & ~in;
    prev = m_cnt;
    if (!on)     m_cnt = '0;
    else if (tk) m_cnt = prev + 1'b1;
    m_txv = on & ta;
    m_rxv = on & ra;
    if (m_txv) m_tx = prev;
    if (m_rxv) m_rx = prev;
    @(negedge clk);
    if (!on)
      chk(count == m_cnt, in ? "R5 init clears count" : "R4 disable clears count", count, m_cnt);
    else if (tk)
      chk(count == m_cnt, (&prev) ? "R6 wrap" : "R2 tick increments", count, m_cnt);
    else
      chk(count == m_cnt, "R3 hold without tick", count, m_cnt);
    chk(tx_stamp_valid == m_txv, m_txv ? "R7 tx valid" : "R9 tx no valid", W'(tx_stamp_valid), W'(m_txv));
    chk(rx_stamp_valid == m_rxv, m_rxv ? "R8 rx valid" : "R9 rx no valid", W'(rx_stamp_valid), W'(m_rxv));
    chk(tx_stamp == m_tx, m_txv ? "R7 tx stamp" : "R9 tx stamp kept", tx_stamp, m_tx);
    chk(rx_stamp == m_rx, (m_txv && m_rxv) ? "R10 both stamps" : "R8 rx stamp", rx_stamp, m_rx);
  endtask

  task automatic sweep();
    for (int v = 0; v < 32; v++) begin
      step(v[0], v[1], v[2], v[3], v[4]);
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(count == '0, "R1 reset count", count, '0);
    chk(tx_stamp == '0 && rx_stamp == '0, "R1 reset stamps", tx_stamp | rx_stamp, '0);
    chk(!tx_stamp_valid && !rx_stamp_valid, "R1 reset valids", W'({tx_stamp_valid, rx_stamp_valid}), '0);
    // sweep near zero
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    sweep();
    // run up to just below the wrap point, with acks sprinkled in
    for (int i = 0; i < 65530; i++) step(1'b1, 1'b1, 1'b0, i[9:0] == 10'd7, i[10:0] == 11'd3);
    sweep();
    // ack at the wrap edge itself
    for (int i = 0; i < 65540; i++) step(1'b1, 1'b1, 1'b0, (&m_cnt), (&m_cnt));
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule